// File: doc/BRIEF.md
# Host-to-Local Pass-Through Data Channel

This block links a host-bus target port to a simple local agent. A host initiator opens an access with an address phase. The block compares that address against four fixed windows. On a hit it stores the address and the access attributes, then moves a stream of 32-bit words between the two sides. A host write is carried to the local agent. For a host read, the local agent supplies the words.

Data passes through a two-entry buffer. The local agent watches an active-low attention output together with the status outputs: window number, direction, byte enables, burst flag and captured address. It moves one word on each rising edge where attention is low and its own ready input is high. On the host side, target-ready shows when a data phase can complete. In a read, this prefetches up to two words ahead of the host. The burst flag goes low once a multi-word burst is seen. It returns high as soon as the host's final word has been exchanged, so one or two words may still be waiting for the local agent at that point.

Top module: `pt_channel`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `l_attn_n` and `l_burst_n` are 1 and `h_trdy` is 0.
- R2: An address phase (`h_adr_vld`=1) while idle is accepted only if address bits [31:12] equal those of a window base. The bases are 0x1000_0000, 0x2000_0000, 0x3000_0000 and 0x4000_0000 for windows 0 to 3. After acceptance, `l_region` gives the window index and `l_addr` gives the full address. A miss leaves `l_addr` unchanged, `h_trdy` at 0 and `l_attn_n` at 1.
- R3: On acceptance, `l_dir` takes `h_wr` (1 means host write, 0 means host read) and `l_be_n` takes `h_be_n`. Both hold for the whole access.
- R4: `l_burst_n` is 1 after acceptance. It goes to 0 after a data phase with `h_last`=0. It goes back to 1 after the data phase with `h_last`=1. A single-phase access never drives it low.
- R5: In a host write, a word is handed over at each rising edge where `l_attn_n`=0 and `l_rdy`=1. While `l_rdy` is 0, `l_dout` keeps the same word and `l_attn_n` stays 0. Words reach `l_dout` in host order.
- R6: In a host write, `l_attn_n` is 1 whenever no word is buffered, including when the host inserts wait states (`h_irdy`=0).
- R7: In a host write, `h_trdy` is 0 while two words are buffered. If two words are pending when the burst flag returns high, `l_attn_n` stays 0 across the next handoff.
- R8: While an access is open, further address phases are ignored. After the last word is taken, `l_attn_n` returns to 1. The access closes one cycle later, and an address phase in the following cycle is accepted.
- R9: In a host read, `h_trdy` is 1 only while a word is buffered. `h_rdata` returns the `l_din` words in the order they were taken. `l_attn_n` is 0 only while the buffer has room and the host has not finished.
- R10: In a host read, the data phase with `h_last`=1 closes the access at once. Prefetched words are discarded, and in the next cycle `l_attn_n`=1, `h_trdy`=0 and `l_burst_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| h_adr_vld | input | 1 | Host address phase strobe |
| h_addr | input | 32 | Host address |
| h_wr | input | 1 | Host direction, 1 = write |
| h_be_n | input | 4 | Host byte enables, active low |
| h_irdy | input | 1 | Host initiator ready for this data phase |
| h_last | input | 1 | Marks the final host data phase |
| h_wdata | input | 32 | Host write word |
| h_trdy | output | 1 | Target ready toward the host |
| h_rdata | output | 32 | Host read word |
| l_attn_n | output | 1 | Local attention, active low |
| l_region | output | 2 | Window index of the open access |
| l_dir | output | 1 | Direction of the open access |
| l_be_n | output | 4 | Captured byte enables |
| l_burst_n | output | 1 | Burst in progress, active low |
| l_addr | output | 32 | Captured host address |
| l_rdy | input | 1 | Local ready, completes a handoff |
| l_dout | output | 32 | Word offered to the local agent |
| l_din | input | 32 | Word supplied by the local agent |

## Verification
All state changes at the rising edge, and every output is decoded from registers only. So a result is due one edge after the cycle that caused it. Address capture, status, the burst flag and the buffer level change one cycle after the address or data phase, and completion shows one further cycle after the buffer empties. The bench drives inputs just after each rising edge and samples at the falling edge. Each directed check is placed in the cycle counted for it. A scoreboard compares every handed-over word against the order of the words pushed by the host-side driver or the local agent.

// File: rtl/pt_chan_pkg.sv
`timescale 1ns/100ps
package pt_chan_pkg;
  typedef enum logic {PT_RD = 1'b0, PT_WR = 1'b1} pt_dir_e;
  localparam int PT_NREG = 4;
endpackage

// File: rtl/ptc_region_decode.sv
`timescale 1ns/100ps
module ptc_region_decode #(
  parameter int AW = 32,
  parameter int NREG = 4,
  parameter int SZ_LOG2 = 12,
  parameter logic [NREG*AW-1:0] BASES = '0,
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic [AW-SZ_LOG2-1:0] addr_hi,
  output logic                  hit,
  output logic [IW-1:0]         idx
);
  logic [NREG-1:0] match;

  for (genvar k = 0; k < NREG; k++) begin : g_win
    assign match[k] = (addr_hi == BASES[k*AW+SZ_LOG2 +: AW-SZ_LOG2]);
  end

  // lowest window index wins when windows overlap
  always_comb begin
    hit = |match;
    idx = '0;
    for (int k = NREG - 1; k >= 0; k--) begin
      if (match[k]) idx = IW'(k);
    end
  end
endmodule

// File: rtl/ptc_buf2.sv
`timescale 1ns/100ps
module ptc_buf2 #(
  parameter int DW = 32,
  parameter int DEPTH = 2,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          empty,
  output logic          full
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] rptr, wptr;
  logic [CW-1:0] cnt;
  logic do_push, do_pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr];

  // storage has no reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rptr <= '0;
      wptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= bump(wptr);
      if (do_pop)  rptr <= bump(rptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/ptc_seq.sv
`timescale 1ns/100ps
module ptc_seq
  import pt_chan_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic adr_vld,
  input  logic adr_hit,
  input  logic wr_req,
  input  logic irdy,
  input  logic last,
  input  logic lrdy,
  input  logic buf_empty,
  input  logic buf_full,
  output logic dir_wr,
  output logic addr_take,
  output logic host_beat,
  output logic local_take,
  output logic flush,
  output logic trdy,
  output logic attn,
  output logic burst_n
);
  logic    active, host_done;
  pt_dir_e dir;

  assign dir_wr     = (dir == PT_WR);
  assign trdy       = active && !host_done && (dir_wr ? !buf_full : !buf_empty);
  assign attn       = active && (dir_wr ? !buf_empty : (!buf_full && !host_done));
  assign host_beat  = irdy && trdy;
  assign local_take = attn && lrdy;
  assign addr_take  = adr_vld && !active && adr_hit;
  assign flush      = host_beat && last && !dir_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      host_done <= 1'b0;
      burst_n   <= 1'b1;
      dir       <= PT_RD;
    end else if (addr_take) begin
      active    <= 1'b1;
      host_done <= 1'b0;
      burst_n   <= 1'b1;
      dir       <= wr_req ? PT_WR : PT_RD;
    end else if (active) begin
      if (host_beat) begin
        burst_n <= last;
        if (last) begin
          host_done <= 1'b1;
          if (!dir_wr) active <= 1'b0;
        end
      end
      if (dir_wr && host_done && buf_empty) active <= 1'b0;
    end
  end
endmodule

// File: rtl/pt_channel.sv
`timescale 1ns/100ps
module pt_channel
  import pt_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int NREG = PT_NREG,
  parameter int SZ_LOG2 = 12,
  parameter int DEPTH = 2,
  parameter logic [NREG*AW-1:0] BASES =
    {32'h4000_0000, 32'h3000_0000, 32'h2000_0000, 32'h1000_0000},
  localparam int BEW = DW / 8,
  localparam int RW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           h_adr_vld,
  input  logic [AW-1:0]  h_addr,
  input  logic           h_wr,
  input  logic [BEW-1:0] h_be_n,
  input  logic           h_irdy,
  input  logic           h_last,
  input  logic [DW-1:0]  h_wdata,
  output logic           h_trdy,
  output logic [DW-1:0]  h_rdata,
  output logic           l_attn_n,
  output logic [RW-1:0]  l_region,
  output logic           l_dir,
  output logic [BEW-1:0] l_be_n,
  output logic           l_burst_n,
  output logic [AW-1:0]  l_addr,
  input  logic           l_rdy,
  output logic [DW-1:0]  l_dout,
  input  logic [DW-1:0]  l_din
);
  logic          hit;
  logic [RW-1:0] hit_idx;
  logic          dir_wr, addr_take, host_beat, local_take, flush, attn;
  logic          buf_empty, buf_full;
  logic [DW-1:0] buf_head;

  ptc_region_decode #(
    .AW(AW), .NREG(NREG), .SZ_LOG2(SZ_LOG2), .BASES(BASES)
  ) u_dec (
    .addr_hi(h_addr[AW-1:SZ_LOG2]),
    .hit    (hit),
    .idx    (hit_idx)
  );

  ptc_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .adr_vld   (h_adr_vld),
    .adr_hit   (hit),
    .wr_req    (h_wr),
    .irdy      (h_irdy),
    .last      (h_last),
    .lrdy      (l_rdy),
    .buf_empty (buf_empty),
    .buf_full  (buf_full),
    .dir_wr    (dir_wr),
    .addr_take (addr_take),
    .host_beat (host_beat),
    .local_take(local_take),
    .flush     (flush),
    .trdy      (h_trdy),
    .attn      (attn),
    .burst_n   (l_burst_n)
  );

  ptc_buf2 #(.DW(DW), .DEPTH(DEPTH)) u_buf (
    .clk  (clk),
    .rst  (rst),
    .flush(flush),
    .push (dir_wr ? host_beat : local_take),
    .din  (dir_wr ? h_wdata : l_din),
    .pop  (dir_wr ? local_take : host_beat),
    .dout (buf_head),
    .empty(buf_empty),
    .full (buf_full)
  );

  // access attributes captured at the accepted address phase
  always_ff @(posedge clk) begin
    if (rst) begin
      l_region <= '0;
      l_dir    <= 1'b0;
      l_be_n   <= '1;
      l_addr   <= '0;
    end else if (addr_take) begin
      l_region <= hit_idx;
      l_dir    <= h_wr;
      l_be_n   <= h_be_n;
      l_addr   <= h_addr;
    end
  end

  assign l_attn_n = !attn;
  assign l_dout   = buf_head;
  assign h_rdata  = buf_head;
endmodule

// File: rtl/pt_channel_chk.sv
`timescale 1ns/100ps
module pt_channel_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          h_adr_vld,
  input logic          h_irdy,
  input logic          h_last,
  input logic          h_trdy,
  input logic          l_attn_n,
  input logic          l_dir,
  input logic          l_burst_n,
  input logic [AW-1:0] l_addr,
  input logic          l_rdy,
  input logic [DW-1:0] l_dout
);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (l_attn_n && l_burst_n && !h_trdy));

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !h_adr_vld |=> $stable(l_addr));

  // R8
  no_reopen_chk: assert property (@(posedge clk) disable iff (rst)
    !l_attn_n |=> $stable(l_addr));

  // R5
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!l_attn_n && !l_rdy && l_dir) |=> ($stable(l_dout) && !l_attn_n));

  // R4
  burst_end_chk: assert property (@(posedge clk) disable iff (rst)
    (h_irdy && h_trdy && h_last) |=> l_burst_n);

  // R10
  read_close_chk: assert property (@(posedge clk) disable iff (rst)
    (h_irdy && h_trdy && h_last && !l_dir) |=> (l_attn_n && !h_trdy));
endmodule

bind pt_channel pt_channel_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .h_adr_vld(h_adr_vld),
  .h_irdy   (h_irdy),
  .h_last   (h_last),
  .h_trdy   (h_trdy),
  .l_attn_n (l_attn_n),
  .l_dir    (l_dir),
  .l_burst_n(l_burst_n),
  .l_addr   (l_addr),
  .l_rdy    (l_rdy),
  .l_dout   (l_dout)
);

// File: tb/tb_pt_channel.sv
`timescale 1ns/100ps
module tb_pt_channel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        h_adr_vld = 1'b0;
  logic [31:0] h_addr = '0;
  logic        h_wr = 1'b0;
  logic [3:0]  h_be_n = 4'hF;
  logic        h_irdy = 1'b0;
  logic        h_last = 1'b0;
  logic [31:0] h_wdata = '0;
  logic        h_trdy;
  logic [31:0] h_rdata;
  logic        l_attn_n;
  logic [1:0]  l_region;
  logic        l_dir;
  logic [3:0]  l_be_n;
  logic        l_burst_n;
  logic [31:0] l_addr;
  logic        l_rdy = 1'b0;
  logic [31:0] l_dout;
  logic [31:0] l_din;

  int errors = 0;
  int checks = 0;
  int rd_pops = 0;
  bit cur_wr = 1'b1;
  bit took_rd = 1'b0;
  bit done = 1'b0;
  logic [31:0] wr_q[$];
  logic [31:0] rd_q[$];

  pt_channel dut (
    .clk(clk), .rst(rst), .h_adr_vld(h_adr_vld), .h_addr(h_addr), .h_wr(h_wr),
    .h_be_n(h_be_n), .h_irdy(h_irdy), .h_last(h_last), .h_wdata(h_wdata),
    .h_trdy(h_trdy), .h_rdata(h_rdata), .l_attn_n(l_attn_n), .l_region(l_region),
    .l_dir(l_dir), .l_be_n(l_be_n), .l_burst_n(l_burst_n), .l_addr(l_addr),
    .l_rdy(l_rdy), .l_dout(l_dout), .l_din(l_din)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic av, input logic [31:0] a, input logic w,
                       input logic [3:0] be, input logic irdy, input logic [31:0] wd,
                       input logic last, input logic rdy);
    h_adr_vld = av; h_addr = a; h_wr = w; h_be_n = be;
    h_irdy = irdy; h_wdata = wd; h_last = last; l_rdy = rdy;
  endtask

  // host-side driver: sample point, pushes each accepted write word
  task automatic tick;
    @(negedge clk);
    if (cur_wr && h_irdy && h_trdy) wr_q.push_back(h_wdata);
  endtask

  task automatic nxt;
    @(posedge clk);
    #1;
  endtask

  // local agent: supplies a new read word after each take
  always @(posedge clk) begin
    #1;
    if (rst) l_din <= 32'hB000_0000;
    else if (took_rd) l_din <= l_din + 32'h1;
  end

  // monitor: compares handed-over words against the expected order
  always @(negedge clk) begin
    took_rd = 1'b0;
    if (!rst) begin
      if (cur_wr && !l_attn_n && l_rdy) begin
        if (wr_q.size() == 0) chk("R5 unexpected local handoff", 32'h1, 32'h0);
        else chk("R5 local word order", l_dout, wr_q.pop_front());
      end
      if (!cur_wr && h_irdy && h_trdy) begin
        rd_pops++;
        if (rd_q.size() == 0) chk("R9 unexpected host read", 32'h1, 32'h0);
        else chk("R9 host read order", h_rdata, rd_q.pop_front());
      end
      if (!cur_wr && !l_attn_n && l_rdy) begin
        took_rd = 1'b1;
        rd_q.push_back(l_din);
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    drive(0, 0, 0, 4'hF, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    #1;
    tick; chk("R1 attn during reset", l_attn_n, 1); chk("R1 burst during reset", l_burst_n, 1);
    nxt; rst = 1'b0;
    tick; chk("R1 attn after reset", l_attn_n, 1); chk("R1 burst after reset", l_burst_n, 1);
    chk("R1 trdy after reset", h_trdy, 0);
    nxt;

    // host write to window 2, slow local agent
    cur_wr = 1'b1;
    drive(1, 32'h3000_0040, 1, 4'b1100, 0, 0, 0, 0); tick; nxt;
    drive(0, 0, 0, 4'hF, 1, 32'hA000_0000, 0, 0); tick;
    chk("R2 region", l_region, 2); chk("R2 address", l_addr, 32'h3000_0040);
    chk("R3 direction", l_dir, 1); chk("R3 byte enables", l_be_n, 4'b1100);
    chk("R6 attn empty", l_attn_n, 1); chk("R4 burst idle", l_burst_n, 1);
    chk("R7 trdy room", h_trdy, 1);
    nxt;
    drive(0, 0, 0, 4'hF, 1, 32'hA000_0001, 0, 0); tick;
    chk("R5 attn word", l_attn_n, 0); chk("R4 burst seen", l_burst_n, 0);
    nxt;
    drive(1, 32'h1000_0000, 1, 4'h0, 1, 32'hA000_0002, 1, 0); tick;
    chk("R7 trdy full", h_trdy, 0); chk("R5 word held", l_dout, 32'hA000_0000);
    chk("R5 attn held", l_attn_n, 0);
    nxt;
    drive(0, 0, 0, 4'hF, 1, 32'hA000_0002, 1, 1); tick;
    chk("R8 address ignored", l_addr, 32'h3000_0040); chk("R5 word still", l_dout, 32'hA000_0000);
    nxt;
    drive(0, 0, 0, 4'hF, 1, 32'hA000_0002, 1, 0); tick;
    chk("R7 trdy after handoff", h_trdy, 1);
    nxt;
    drive(0, 0, 0, 4'hF, 0, 0, 0, 1); tick;
    chk("R4 burst ended", l_burst_n, 1); chk("R7 attn two pending", l_attn_n, 0);
    nxt;
    drive(0, 0, 0, 4'hF, 0, 0, 0, 1); tick;
    chk("R7 attn kept", l_attn_n, 0); chk("R7 second word", l_dout, 32'hA000_0002);
    nxt;
    drive(1, 32'h1000_0010, 1, 4'h0, 0, 0, 0, 0); tick;
    chk("R8 attn released", l_attn_n, 1);
    nxt;
    drive(1, 32'h4000_0008, 1, 4'h0, 0, 0, 0, 0); tick;
    chk("R8 closing phase ignored", l_region, 2); chk("R8 address kept", l_addr, 32'h3000_0040);
    nxt;
    drive(0, 0, 0, 4'hF, 1, 32'hC000_0000, 1, 0); tick;
    chk("R8 reopen region", l_region, 3); chk("R8 reopen address", l_addr, 32'h4000_0008);
    nxt;
    drive(0, 0, 0, 4'hF, 0, 0, 0, 1); tick;
    chk("R4 single phase burst", l_burst_n, 1); chk("R5 single word attn", l_attn_n, 0);
    nxt;
    drive(0, 0, 0, 4'hF, 0, 0, 0, 0); tick;
    chk("R8 single done", l_attn_n, 1);
    nxt; nxt;

    // address miss
    drive(1, 32'h5000_0000, 1, 4'h0, 0, 0, 0, 0); tick; nxt;
    drive(0, 0, 0, 4'hF, 0, 0, 0, 0); tick;
    chk("R2 miss attn", l_attn_n, 1); chk("R2 miss trdy", h_trdy, 0);
    chk("R2 miss address", l_addr, 32'h4000_0008);
    nxt;

    // host write with a host wait state, window 0
    drive(1, 32'h1000_0020, 1, 4'h0, 0, 0, 0, 0); tick; nxt;
    drive(0, 0, 0, 4'hF, 1, 32'hD000_0000, 0, 1); tick;
    chk("R2 window 0", l_region, 0);
    nxt;
    drive(0, 0, 0, 4'hF, 0, 0, 0, 1); tick;
    chk("R6 word ready", l_attn_n, 0);
    nxt;
    drive(0, 0, 0, 4'hF, 1, 32'hD000_0001, 1, 1); tick;
    chk("R6 attn during host wait", l_attn_n, 1);
    nxt;
    drive(0, 0, 0, 4'hF, 0, 0, 0, 1); tick;
    chk("R6 attn back", l_attn_n, 0); chk("R6 word after wait", l_dout, 32'hD000_0001);
    nxt;
    drive(0, 0, 0, 4'hF, 0, 0, 0, 0); tick;
    chk("R8 write done", l_attn_n, 1);
    nxt; nxt;
    chk("R5 all words delivered", wr_q.size(), 0);

    // host read from window 1 with prefetch
    cur_wr = 1'b0;
    drive(1, 32'h2000_0100, 0, 4'h0, 0, 0, 0, 1); tick; nxt;
    drive(0, 0, 0, 4'hF, 1, 0, 0, 1); tick;
    chk("R9 attn read", l_attn_n, 0); chk("R9 trdy empty", h_trdy, 0);
    chk("R3 read dir", l_dir, 0); chk("R2 window 1", l_region, 1);
    nxt;
    drive(0, 0, 0, 4'hF, 1, 0, 0, 1); tick;
    chk("R9 trdy word", h_trdy, 1);
    nxt;
    drive(0, 0, 0, 4'hF, 0, 0, 0, 1); tick; nxt;
    drive(0, 0, 0, 4'hF, 1, 0, 0, 1); tick;
    chk("R9 attn full", l_attn_n, 1);
    nxt;
    drive(0, 0, 0, 4'hF, 1, 0, 1, 1); tick;
    chk("R4 read burst", l_burst_n, 0);
    nxt;
    drive(0, 0, 0, 4'hF, 0, 0, 0, 0); tick;
    chk("R10 attn closed", l_attn_n, 1); chk("R10 trdy closed", h_trdy, 0);
    chk("R10 burst closed", l_burst_n, 1); chk("R9 host beats", rd_pops, 3);
    nxt; nxt;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule